// File: doc/BRIEF.md
# UART Break Detector and Length Meter

This block sits beside a UART receiver and watches for a break: the line held at zero for a full character time or longer, stop position included. The receiver reports each finished character with a strobe and an all-zero flag. The block declares a break after one such character. In resynchronising synchronous operation it needs two consecutive all-zero characters instead. On detection it pulses a break-start event and bumps a saturating break counter. If a character was being assembled into a receive buffer at that moment, it also asks for that buffer to be closed and tagged as ended by a break.

While the line stays low, the block counts bit strobes and converts them into whole character times. The first sampled high level ends the break. The block then stores the length in a saturating register and pulses a break-end event. A single interrupt line combines the three event kinds, each under its own enable. After a break, detection stays disarmed until one bit strobe sees the line high. This keeps a long break from being counted twice.

Top module: `uart_break_monitor`

## Requirements
- R1: After reset, every output is zero: the event pulses, the interrupt, the counter and the length register.
- R2: While armed, `char_done_i` with `char_zero_i`=1 (a character whose bits, stop included, were all zero) meeting the threshold pulses `brk_start_o` for one cycle, in the cycle after the strobe. The same edge adds one to `brk_cnt_o`, which saturates at all ones.
- R3: The threshold is two consecutive all-zero characters when `sync_mode_i`=1 and `resync_en_i`=1, and one otherwise. Any character with `char_zero_i`=0 between two zero characters restarts the run.
- R4: A break sequence adds exactly one to the counter, however many further zero characters or bits it lasts.
- R5: The first cycle with `rx_line_i`=1 during a break ends it. One cycle later `brk_end_o` pulses and `brk_len_o` takes this value: the threshold (1 or 2) plus floor(low bit strobes after detection / CHAR_BITS), saturated at 2^LEN_W-1. Start and end never pulse in the same cycle.
- R6: `brk_len_o` changes only in a cycle where `brk_end_o` pulses and holds otherwise.
- R7: If `rx_busy_i`=1 in the detecting cycle, `buf_close_brk_o` pulses in the same cycle as `brk_start_o`. Otherwise it stays low.
- R8: `irq_o` pulses in an event cycle when a matching enable was set in the cycle the event was decided. The pairs are start with `ie_start_i`, end with `ie_end_i`, and buffer close with `ie_rx_i`. With no enabled event, `irq_o` stays low.
- R9: After a break ends, zero characters are ignored until a bit strobe sees `rx_line_i`=1. Only then can a new break be detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | 1 | Sampled receive line level |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| char_done_i | input | 1 | Receiver finished a character |
| char_zero_i | input | 1 | The finished character was all zero, stop included |
| rx_busy_i | input | 1 | A receive buffer is partly filled |
| sync_mode_i | input | 1 | Synchronous operation selected |
| resync_en_i | input | 1 | Resynchronising option (two-character threshold in sync mode) |
| ie_start_i | input | 1 | Interrupt enable for break start |
| ie_end_i | input | 1 | Interrupt enable for break end |
| ie_rx_i | input | 1 | Interrupt enable for break-closed buffer |
| brk_start_o | output | 1 | Break-start event pulse |
| brk_end_o | output | 1 | Break-end event pulse |
| brk_cnt_o | output | CNT_W | Saturating count of break sequences |
| brk_len_o | output | LEN_W | Last break length in character times |
| buf_close_brk_o | output | 1 | Close the receive buffer, tagged as ended by a break |
| irq_o | output | 1 | Combined interrupt pulse |

## Verification
Break start and the break-tagged buffer close land in the same cycle whenever a character is in progress at detection. Random cases toggle `rx_busy_i` and the three enables to provoke this. Each case is judged by counting start, close and interrupt pulses. Since both events share one interrupt cycle, exactly one interrupt pulse is expected when either enable is set, never two. A second instance with a narrow length register runs the same stimulus, so that length saturation and ordinary length growth are checked together.

// File: rtl/ubm_pkg.sv
package ubm_pkg;
   typedef enum logic [1:0] {
      ST_ARMED = 2'd0,
      ST_BREAK = 2'd1,
      ST_REARM = 2'd2
   } ubm_state_e;

   localparam int unsigned UBM_THR_W = 2;
endpackage

// File: rtl/ubm_zero_qual.sv
module ubm_zero_qual
   import ubm_pkg::*;
#(
   parameter bit RESYNC_SUPPORT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_i,
   input  logic                 char_done_i,
   input  logic                 char_zero_i,
   input  logic                 need_two_i,
   output logic                 hit_o,
   output logic [UBM_THR_W-1:0] thr_o
);
   logic zchar;
   assign zchar = char_done_i & char_zero_i;

   generate
      if (RESYNC_SUPPORT) begin : g_two
         logic seen_one_q;
         logic two_eff;
         assign two_eff = need_two_i;
         assign hit_o   = zchar & (~two_eff | seen_one_q);
         assign thr_o   = two_eff ? UBM_THR_W'(2) : UBM_THR_W'(1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_one_q <= 1'b0;
            end else if (clear_i) begin
               seen_one_q <= 1'b0;
            end else if (char_done_i) begin
               seen_one_q <= zchar & ~hit_o;
            end
         end
      end else begin : g_one
         logic unused_two;
         assign unused_two = need_two_i ^ clear_i;
         assign hit_o = zchar;
         assign thr_o = UBM_THR_W'(1);
      end
   endgenerate
endmodule

// File: rtl/ubm_len_meter.sv
module ubm_len_meter
   import ubm_pkg::*;
#(
   parameter int unsigned CHAR_BITS = 10,
   parameter int unsigned LEN_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic [UBM_THR_W-1:0] load_val_i,
   input  logic                 run_i,
   input  logic                 bit_tick_i,
   output logic [LEN_W-1:0]     len_o
);
   localparam int unsigned BC_W = (CHAR_BITS > 1) ? $clog2(CHAR_BITS) : 1;
   localparam logic [BC_W-1:0] BC_LAST = BC_W'(CHAR_BITS - 1);
   localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

   logic [BC_W-1:0]  bit_cnt_q;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q <= '0;
         len_q     <= '0;
      end else if (load_i) begin
         bit_cnt_q <= '0;
         len_q     <= LEN_W'(load_val_i);
      end else if (run_i && bit_tick_i) begin
         if (bit_cnt_q == BC_LAST) begin
            bit_cnt_q <= '0;
            if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
         end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
         end
      end
   end

   assign len_o = len_q;
endmodule

// File: rtl/ubm_evt.sv
module ubm_evt #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_start_i,
   input  logic             fire_end_i,
   input  logic             fire_close_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             ie_start_i,
   input  logic             ie_end_i,
   input  logic             ie_rx_i,
   output logic             start_o,
   output logic             end_o,
   output logic             close_o,
   output logic             irq_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [LEN_W-1:0] len_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic irq_d;
   assign irq_d = (fire_start_i & ie_start_i) | (fire_end_i & ie_end_i) |
                  (fire_close_i & ie_rx_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o <= 1'b0;
         end_o   <= 1'b0;
         close_o <= 1'b0;
         irq_o   <= 1'b0;
         cnt_o   <= '0;
         len_o   <= '0;
      end else begin
         start_o <= fire_start_i;
         end_o   <= fire_end_i;
         close_o <= fire_close_i;
         irq_o   <= irq_d;
         if (fire_start_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
         if (fire_end_i) len_o <= len_i;
      end
   end
endmodule

// File: rtl/uart_break_monitor.sv
module uart_break_monitor
   import ubm_pkg::*;
#(
   parameter int unsigned CHAR_BITS      = 10,
   parameter int unsigned LEN_W          = 16,
   parameter int unsigned CNT_W          = 8,
   parameter bit          RESYNC_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_line_i,
   input  logic             bit_tick_i,
   input  logic             char_done_i,
   input  logic             char_zero_i,
   input  logic             rx_busy_i,
   input  logic             sync_mode_i,
   input  logic             resync_en_i,
   input  logic             ie_start_i,
   input  logic             ie_end_i,
   input  logic             ie_rx_i,
   output logic             brk_start_o,
   output logic             brk_end_o,
   output logic [CNT_W-1:0] brk_cnt_o,
   output logic [LEN_W-1:0] brk_len_o,
   output logic             buf_close_brk_o,
   output logic             irq_o
);
   generate
      if (CHAR_BITS < 2) begin : g_bad_char
         $error("CHAR_BITS must be at least 2");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("LEN_W must hold the two-character threshold");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   ubm_state_e           state_q;
   logic                 hit;
   logic [UBM_THR_W-1:0] thr;
   logic                 detect;
   logic                 finish;
   logic                 rearm;
   logic [LEN_W-1:0]     len_live;

   assign detect = (state_q == ST_ARMED) & hit;
   assign finish = (state_q == ST_BREAK) & rx_line_i;
   assign rearm  = (state_q == ST_REARM) & bit_tick_i & rx_line_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ARMED;
      end else begin
         unique case (state_q)
            ST_ARMED: if (detect) state_q <= ST_BREAK;
            ST_BREAK: if (finish) state_q <= ST_REARM;
            ST_REARM: if (rearm)  state_q <= ST_ARMED;
            default:              state_q <= ST_ARMED;
         endcase
      end
   end

   ubm_zero_qual #(.RESYNC_SUPPORT(RESYNC_SUPPORT)) u_qual (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (state_q != ST_ARMED),
      .char_done_i (char_done_i),
      .char_zero_i (char_zero_i),
      .need_two_i  (sync_mode_i & resync_en_i),
      .hit_o       (hit),
      .thr_o       (thr)
   );

   ubm_len_meter #(.CHAR_BITS(CHAR_BITS), .LEN_W(LEN_W)) u_len (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (detect),
      .load_val_i (thr),
      .run_i      ((state_q == ST_BREAK) & ~rx_line_i),
      .bit_tick_i (bit_tick_i),
      .len_o      (len_live)
   );

   ubm_evt #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_evt (
      .clk          (clk),
      .rst_n        (rst_n),
      .fire_start_i (detect),
      .fire_end_i   (finish),
      .fire_close_i (detect & rx_busy_i),
      .len_i        (len_live),
      .ie_start_i   (ie_start_i),
      .ie_end_i     (ie_end_i),
      .ie_rx_i      (ie_rx_i),
      .start_o      (brk_start_o),
      .end_o        (brk_end_o),
      .close_o      (buf_close_brk_o),
      .irq_o        (irq_o),
      .cnt_o        (brk_cnt_o),
      .len_o        (brk_len_o)
   );
endmodule

// File: rtl/ubm_check.sv
module ubm_check #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ie_start_i,
   input logic             ie_end_i,
   input logic             ie_rx_i,
   input logic             brk_start_o,
   input logic             brk_end_o,
   input logic [CNT_W-1:0] brk_cnt_o,
   input logic [LEN_W-1:0] brk_len_o,
   input logic             buf_close_brk_o,
   input logic             irq_o
);
   a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_start_o && ($past(brk_cnt_o) != {CNT_W{1'b1}}))
         |-> (brk_cnt_o == CNT_W'($past(brk_cnt_o) + 1'b1)));

   a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_start_o |-> $stable(brk_cnt_o));

   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(brk_start_o && brk_end_o));

   a_r6_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_end_o |-> $stable(brk_len_o));

   a_r7_close_with_start: assert property (@(posedge clk) disable iff (!rst_n)
      buf_close_brk_o |-> brk_start_o);

   a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((brk_start_o && $past(ie_start_i)) ||
                 (brk_end_o && $past(ie_end_i)) ||
                 (buf_close_brk_o && $past(ie_rx_i))));
endmodule

bind uart_break_monitor ubm_check #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ie_start_i      (ie_start_i),
   .ie_end_i        (ie_end_i),
   .ie_rx_i         (ie_rx_i),
   .brk_start_o     (brk_start_o),
   .brk_end_o       (brk_end_o),
   .brk_cnt_o       (brk_cnt_o),
   .brk_len_o       (brk_len_o),
   .buf_close_brk_o (buf_close_brk_o),
   .irq_o           (irq_o)
);

// File: tb/sim_uart_break_monitor.sv
module sim_uart_break_monitor;
   localparam int CB = 10;
   localparam int LW = 16;
   localparam int LW_S = 3;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_line = 1'b1, bit_tick = 1'b0, char_done = 1'b0, char_zero = 1'b0;
   logic rx_busy = 1'b0, sync_mode = 1'b0, resync_en = 1'b0;
   logic ie_s = 1'b0, ie_e = 1'b0, ie_r = 1'b0;

   logic brk_start, brk_end, close, irq;
   logic [CW-1:0] cnt;
   logic [LW-1:0] len;
   logic brk_start_s, brk_end_s, close_s, irq_s;
   logic [CW-1:0] cnt_s;
   logic [LW_S-1:0] len_s;

   always #5 clk = ~clk;

   uart_break_monitor #(.CHAR_BITS(CB), .LEN_W(LW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_line_i(rx_line), .bit_tick_i(bit_tick),
      .char_done_i(char_done), .char_zero_i(char_zero), .rx_busy_i(rx_busy),
      .sync_mode_i(sync_mode), .resync_en_i(resync_en), .ie_start_i(ie_s),
      .ie_end_i(ie_e), .ie_rx_i(ie_r), .brk_start_o(brk_start), .brk_end_o(brk_end),
      .brk_cnt_o(cnt), .brk_len_o(len), .buf_close_brk_o(close), .irq_o(irq));

   uart_break_monitor #(.CHAR_BITS(CB), .LEN_W(LW_S), .CNT_W(CW)) u1 (
      .clk(clk), .rst_n(rst_n), .rx_line_i(rx_line), .bit_tick_i(bit_tick),
      .char_done_i(char_done), .char_zero_i(char_zero), .rx_busy_i(rx_busy),
      .sync_mode_i(sync_mode), .resync_en_i(resync_en), .ie_start_i(ie_s),
      .ie_end_i(ie_e), .ie_rx_i(ie_r), .brk_start_o(brk_start_s), .brk_end_o(brk_end_s),
      .brk_cnt_o(cnt_s), .brk_len_o(len_s), .buf_close_brk_o(close_s), .irq_o(irq_s));

   int n_chk = 0, n_bad = 0;
   int n_start = 0, n_end = 0, n_close = 0, n_irq = 0, n_late = 0;
   int cyc = 0, done_cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (char_done) done_cyc <= cyc;
      if (cyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (brk_start) begin
            n_start = n_start + 1;
            if (cyc - done_cyc != 1) n_late = n_late + 1;
         end
         if (brk_end) n_end = n_end + 1;
         if (close) n_close = n_close + 1;
         if (irq) n_irq = n_irq + 1;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input logic line, input logic done, input logic zero);
      @(negedge clk);
      rx_line = line; bit_tick = 1'b1; char_done = done; char_zero = zero;
      @(negedge clk);
      bit_tick = 1'b0; char_done = 1'b0; char_zero = 1'b0;
   endtask

   task automatic send_char(input bit zero);
      for (int i = 0; i < CB; i++) begin
         logic b;
         if (zero) b = 1'b0;
         else if (i == 0) b = 1'b0;
         else if (i == CB - 1) b = 1'b1;
         else b = 1'($urandom % 2);
         tick(b, i == CB - 1, zero);
      end
   endtask

   function automatic int exp_len(input int thr, input int n, input int w);
      int v = thr + n / CB;
      int mx = (1 << w) - 1;
      return (v > mx) ? mx : v;
   endfunction

   task automatic run_case(input bit sm, input bit rs, input bit busy, input bit [2:0] ie,
                           input int k, input int n, input bit iso);
      int s0, e0, c0, i0, cnt0, thr, irq_exp;
      sync_mode = sm; resync_en = rs; rx_busy = busy;
      ie_s = ie[0]; ie_e = ie[1]; ie_r = ie[2];
      thr = (sm && rs) ? 2 : 1;
      s0 = n_start; e0 = n_end; c0 = n_close; i0 = n_irq; cnt0 = int'(cnt);
      for (int i = 0; i < k; i++) send_char(1'b0);
      chk("R2 normal chars give no start", n_start - s0, 0);
      if (iso && thr == 2) begin
         send_char(1'b1);
         send_char(1'b0);
         chk("R3 isolated zero char in resync mode", n_start - s0, 0);
      end
      for (int t = 0; t < thr; t++) send_char(1'b1);
      for (int j = 0; j < n; j++) tick(1'b0, (j % CB) == CB - 1, 1'b1);
      @(negedge clk); rx_line = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R2 one start per break", n_start - s0, 1);
      chk("R4 counter steps once", int'(cnt), cnt0 + 1);
      chk("R5 one end per break", n_end - e0, 1);
      chk("R5 length", int'(len), exp_len(thr, n, LW));
      chk("R5 saturated length", int'(len_s), exp_len(thr, n, LW_S));
      chk("R7 buffer close", n_close - c0, int'(busy));
      irq_exp = int'(ie[0] | (busy & ie[2])) + int'(ie[1]);
      chk("R8 interrupt pulses", n_irq - i0, irq_exp);
      tick(1'b1, 1'b0, 1'b0);
      @(negedge clk);
   endtask

   initial begin
      int lsave;
      void'($urandom(32'd20240613));
      repeat (3) @(negedge clk);
      chk("R1 start", int'(brk_start), 0);
      chk("R1 count", int'(cnt), 0);
      chk("R1 length", int'(len), 0);
      chk("R1 irq/close/end", int'({irq, close, brk_end}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: single-char threshold, exact length boundaries
      run_case(1'b0, 1'b0, 1'b1, 3'b111, 1, 0, 1'b0);
      run_case(1'b0, 1'b0, 1'b0, 3'b010, 0, CB - 1, 1'b0);
      run_case(1'b0, 1'b0, 1'b0, 3'b000, 0, CB, 1'b0);
      // resync option only in sync mode
      run_case(1'b0, 1'b1, 1'b1, 3'b100, 1, 3, 1'b0);
      run_case(1'b1, 1'b1, 1'b1, 3'b001, 1, 25, 1'b1);
      run_case(1'b1, 1'b0, 1'b0, 3'b011, 0, 70, 1'b0);

      // R9: no re-detection before a high bit strobe
      ie_s = 1'b0; ie_e = 1'b0; ie_r = 1'b0; sync_mode = 1'b0; resync_en = 1'b0;
      begin
         int s0;
         s0 = n_start;
         send_char(1'b1);
         @(negedge clk); rx_line = 1'b1;
         @(negedge clk); rx_line = 1'b0;
         lsave = int'(len);
         send_char(1'b1);
         send_char(1'b1);
         @(negedge clk);
         chk("R9 ignored while disarmed", n_start - s0, 1);
         chk("R6 length held", int'(len), lsave);
         tick(1'b1, 1'b0, 1'b0);
         send_char(1'b1);
         @(negedge clk); @(negedge clk);
         chk("R9 re-armed after high strobe", n_start - s0, 2);
         @(negedge clk); rx_line = 1'b1;
         @(negedge clk);
         tick(1'b1, 1'b0, 1'b0);
      end

      // constrained random mix
      for (int r = 0; r < 24; r++) begin
         bit sm, rs, bz, iso;
         bit [2:0] ie;
         sm = 1'($urandom % 2); rs = 1'($urandom % 2); bz = 1'($urandom % 2);
         iso = 1'($urandom % 2); ie = 3'($urandom % 8);
         run_case(sm, rs, bz, ie, int'($urandom % 3), int'($urandom % 75), iso);
      end

      chk("R2 start latency one cycle", n_late, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule